// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block converts pointer reports into the five-byte packets of the classic serial mouse format and stores them in a byte queue for a host to drain. Each report carries a signed horizontal motion, a signed vertical motion and three button flags. The block clamps both motion values to the symmetric range -127..+127. It flips the vertical axis so that upward motion is positive. It builds a start byte whose low three bits are cleared for pressed buttons, and then appends two zero bytes.

A producer offers a report with `rpt_valid`. The report is taken only when `rpt_ready` is high. After that, `enc_busy` stays high while the packet is written into the queue, one byte per clock. A consumer pulses `host_pop` to take the oldest byte, which appears on `host_byte` after that clock edge. `host_avail` tells the consumer whether any bytes are waiting.

Top module: `mouse_pkt_enc`

## Requirements
- R1: After a synchronous reset, `host_avail` and `enc_busy` are low, `rpt_ready` is high and `host_byte` is 0x00.
- R2: The first byte of a packet is 0x87 with bit 2 cleared when `rpt_btn[2]` (left) is set, bit 1 cleared when `rpt_btn[1]` (middle) is set, and bit 0 cleared when `rpt_btn[0]` (right) is set.
- R3: The second byte is `rpt_dx` (16-bit two's complement) clamped to -127..+127 and then truncated to 8-bit two's complement. Values of -128 and below give 0x81, and +127 and above give 0x7F.
- R4: The third byte is the negation of `rpt_dy`, clamped to -127..+127 in the same way. The negation is done without overflow, so `rpt_dy` = -32768 gives 0x7F.
- R5: The fourth and fifth bytes are 0x00, and a packet's bytes leave the queue in the order start, X, Y, zero, zero, before any byte of a later packet.
- R6: `rpt_ready` is high exactly when `enc_busy` is low and at least five queue slots are free. A report offered while `rpt_ready` is low is ignored, and no byte is queued for it.
- R7: A report accepted at one clock edge raises `enc_busy` from that edge. Its five bytes are written on the next five edges, one per edge, and `enc_busy` falls at the fifth of those edges.
- R8: `host_avail` is high whenever the queue holds at least one byte, judged after each edge's pop and write.
- R9: A pop at an edge puts the oldest queued byte on `host_byte` from that edge and removes it. A pop while the queue was empty before that edge gives 0x00. Without a pop, `host_byte` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rpt_valid | input | 1 | Report offered |
| rpt_dx | input | 16 | Signed horizontal motion |
| rpt_dy | input | 16 | Signed vertical motion |
| rpt_btn | input | 3 | Buttons: [2] left, [1] middle, [0] right, 1 = pressed |
| rpt_ready | output | 1 | Report will be taken at this edge if offered |
| enc_busy | output | 1 | Packet bytes are being written |
| host_pop | input | 1 | Remove the oldest byte |
| host_byte | output | 8 | Last popped byte |
| host_avail | output | 1 | Queue is not empty |

## Verification
The hardest condition to reach is `rpt_ready` going low because the queue is close to full. This takes several packets in a row with little draining. In the same stretch, pops must land in the same cycles as packet writes, and empty pops must land in the cycle where the first byte of a packet enters. The random phases therefore alternate between a fill regime with rare pops and a drain regime with frequent pops. A cycle-exact bench model of the queue predicts every popped byte and every level of `rpt_ready`. Directed reports cover the clamp edges -32768, -128, -127, 127, 128 and 32767 on both axes, together with all button combinations.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  localparam int PKT_LEN   = 5;
  localparam int BYTE_W    = 8;
  localparam int BTN_W     = 3;
  localparam logic [7:0] START_BASE = 8'h87;
  localparam int SAT_MAX   = 127;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [PKT_LEN-1:0] pkt_t;
endpackage

// File: rtl/mpe_format.sv
module mpe_format
  import mpe_pkg::*;
#(
  parameter int IN_W = 16
) (
  input  logic [IN_W-1:0]  dx,
  input  logic [IN_W-1:0]  dy,
  input  logic [BTN_W-1:0] btn,
  output pkt_t             pkt
);
  localparam int EXT_W = IN_W + 1;

  function automatic byte_t clamp8(input logic signed [EXT_W-1:0] v);
    logic signed [EXT_W-1:0] hi;
    logic signed [EXT_W-1:0] lo;
    hi = EXT_W'(SAT_MAX);
    lo = -EXT_W'(SAT_MAX);
    if (v > hi)      clamp8 = byte_t'(SAT_MAX);
    else if (v < lo) clamp8 = byte_t'(-SAT_MAX);
    else             clamp8 = v[BYTE_W-1:0];
  endfunction

  logic signed [EXT_W-1:0] dx_ext;
  logic signed [EXT_W-1:0] dy_neg;

  always_comb begin
    dx_ext = {dx[IN_W-1], dx};
    dy_neg = -{dy[IN_W-1], dy};
  end

  genvar g;
  generate
    for (g = 0; g < PKT_LEN; g++) begin : g_byte
      if (g == 0) begin : g_start
        assign pkt[g] = START_BASE & ~{{(BYTE_W-BTN_W){1'b0}}, btn};
      end else if (g == 1) begin : g_x
        assign pkt[g] = clamp8(dx_ext);
      end else if (g == 2) begin : g_y
        assign pkt[g] = clamp8(dy_neg);
      end else begin : g_pad
        assign pkt[g] = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/mpe_emit.sv
module mpe_emit
  import mpe_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  accept,
  input  pkt_t  pkt_in,
  output logic  busy,
  output logic  push,
  output byte_t push_data
);
  localparam int IDX_W = $clog2(PKT_LEN);

  pkt_t             pkt_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      idx_q <= '0;
      pkt_q <= '0;
    end else if (busy) begin
      if (idx_q == IDX_W'(PKT_LEN - 1)) begin
        busy  <= 1'b0;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (accept) begin
      busy  <= 1'b1;
      idx_q <= '0;
      pkt_q <= pkt_in;
    end
  end

  assign push      = busy;
  assign push_data = pkt_q[idx_q];
endmodule

// File: rtl/mpe_queue.sv
module mpe_queue
  import mpe_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  byte_t push_data,
  input  logic  pop,
  output byte_t pop_data,
  output logic  avail,
  output logic  room
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int ROOM_LIMIT = DEPTH - PKT_LEN;

  byte_t          mem [DEPTH];
  logic [AW-1:0]  wptr, rptr;
  logic [CW-1:0]  count;
  logic           do_push, do_pop;

  always_comb begin
    do_pop  = pop && (count != '0);
    do_push = push && (count != CW'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (pop) begin
      pop_data <= do_pop ? mem[rptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      avail <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   begin count <= count + 1'b1; avail <= 1'b1; end
        2'b01:   begin count <= count - 1'b1; avail <= (count != CW'(1)); end
        default: ;
      endcase
    end
  end

  assign room = (count <= CW'(ROOM_LIMIT));
endmodule

// File: rtl/mouse_pkt_enc.sv
module mouse_pkt_enc
  import mpe_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rpt_valid,
  input  logic [IN_W-1:0] rpt_dx,
  input  logic [IN_W-1:0] rpt_dy,
  input  logic [2:0]      rpt_btn,
  output logic            rpt_ready,
  output logic            enc_busy,
  input  logic            host_pop,
  output logic [7:0]      host_byte,
  output logic            host_avail
);
  pkt_t  pkt_fmt;
  logic  accept, room, push;
  byte_t push_data;

  mpe_format #(.IN_W(IN_W)) u_format (
    .dx (rpt_dx), .dy (rpt_dy), .btn (rpt_btn), .pkt (pkt_fmt)
  );

  assign rpt_ready = !enc_busy && room;
  assign accept    = rpt_valid && rpt_ready;

  mpe_emit u_emit (
    .clk (clk), .rst (rst), .accept (accept), .pkt_in (pkt_fmt),
    .busy (enc_busy), .push (push), .push_data (push_data)
  );

  mpe_queue #(.DEPTH(DEPTH)) u_queue (
    .clk (clk), .rst (rst), .push (push), .push_data (push_data),
    .pop (host_pop), .pop_data (host_byte), .avail (host_avail), .room (room)
  );
endmodule

// File: rtl/mouse_pkt_enc_chk.sv
module mouse_pkt_enc_chk (
  input logic       clk,
  input logic       rst,
  input logic       rpt_valid,
  input logic       rpt_ready,
  input logic       enc_busy,
  input logic       host_pop,
  input logic [7:0] host_byte,
  input logic       host_avail
);
  logic [3:0] run;
  always_ff @(posedge clk) begin
    if (rst)           run <= '0;
    else if (enc_busy) run <= run + 1'b1;
    else               run <= '0;
  end

  assert_accept_starts_R7: assert property (@(posedge clk) disable iff (rst)
    (rpt_valid && rpt_ready) |=> enc_busy);
  assert_busy_max_R7: assert property (@(posedge clk) disable iff (rst)
    enc_busy |-> run < 4'd5);
  assert_busy_exact_R7: assert property (@(posedge clk) disable iff (rst)
    (!enc_busy && run != 4'd0) |-> run == 4'd5);
  assert_no_ready_busy_R6: assert property (@(posedge clk) disable iff (rst)
    enc_busy |-> !rpt_ready);
  assert_empty_pop_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (host_pop && !host_avail) |=> host_byte == 8'h00);
  assert_avail_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    enc_busy |=> host_avail);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!host_pop && !$past(rst)) |=> $stable(host_byte));
endmodule

bind mouse_pkt_enc mouse_pkt_enc_chk u_chk (
  .clk (clk), .rst (rst), .rpt_valid (rpt_valid), .rpt_ready (rpt_ready),
  .enc_busy (enc_busy), .host_pop (host_pop), .host_byte (host_byte),
  .host_avail (host_avail)
);

// File: tb/mouse_pkt_enc_bench.sv
`timescale 1ns/1ps
module mouse_pkt_enc_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rpt_valid = 1'b0;
  logic [15:0] rpt_dx = '0, rpt_dy = '0;
  logic [2:0]  rpt_btn = '0;
  logic        rpt_ready, enc_busy, host_pop = 1'b0, host_avail;
  logic [7:0]  host_byte;

  always #2.5 clk = ~clk;

  mouse_pkt_enc #(.IN_W(16), .DEPTH(DEPTH)) u_mouse_pkt_enc (
    .clk (clk), .rst (rst), .rpt_valid (rpt_valid), .rpt_dx (rpt_dx),
    .rpt_dy (rpt_dy), .rpt_btn (rpt_btn), .rpt_ready (rpt_ready),
    .enc_busy (enc_busy), .host_pop (host_pop), .host_byte (host_byte),
    .host_avail (host_avail)
  );

  int tests = 0, fails = 0;

  // bench model
  logic [7:0] mq_b [DEPTH];
  int         mq_i [DEPTH];
  int mrd = 0, mwr = 0, mcnt = 0;
  logic [7:0] mpkt [5];
  bit mbusy = 0;
  int midx = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] clamp(input int v);
    if (v > 127)  return 8'h7F;
    if (v < -127) return 8'h81;
    return v[7:0];
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2 start byte";
      1: return "R3 x byte";
      2: return "R4 y byte";
      default: return "R5 pad byte";
    endcase
  endfunction

  task automatic cyc(input bit v, input logic [15:0] dx, input logic [15:0] dy,
                     input logic [2:0] b, input bit p);
    bit exp_ready, acc, chk_rd;
    logic [7:0] exp_rd;
    string rtag;
    rpt_valid = v; rpt_dx = dx; rpt_dy = dy; rpt_btn = b; host_pop = p;
    #0.5;
    exp_ready = !mbusy && (mcnt <= DEPTH - 5);
    chk("R6 ready", rpt_ready, exp_ready);
    acc = v && exp_ready;
    @(posedge clk);
    chk_rd = p;
    rtag = "R9 empty pop";
    exp_rd = 8'h00;
    if (p && mcnt > 0) begin
      exp_rd = mq_b[mrd];
      rtag = tag_of(mq_i[mrd]);
      mrd = (mrd + 1) % DEPTH; mcnt--;
    end
    if (mbusy) begin
      mq_b[mwr] = mpkt[midx]; mq_i[mwr] = midx;
      mwr = (mwr + 1) % DEPTH; mcnt++;
      midx++;
      if (midx == 5) mbusy = 0;
    end
    if (acc) begin
      mpkt[0] = 8'h87 & ~{5'b0, b};
      mpkt[1] = clamp(int'($signed(dx)));
      mpkt[2] = clamp(-int'($signed(dy)));
      mpkt[3] = 8'h00; mpkt[4] = 8'h00;
      mbusy = 1; midx = 0;
    end
    @(negedge clk);
    if (chk_rd) chk(rtag, host_byte, exp_rd);
    chk("R7 busy", enc_busy, mbusy);
    chk("R8 avail", host_avail, mcnt != 0);
  endtask

  function automatic logic [15:0] rnd_val();
    int cls = $urandom_range(0, 3);
    case (cls)
      0: return 16'($urandom_range(0, 255)) - 16'd128;
      1: return 16'($urandom_range(0, 8)) - 16'd4;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] corners [6];
    void'($urandom(32'h5EED1234));
    corners[0] = 16'h8000; corners[1] = 16'hFF80; corners[2] = 16'hFF81;
    corners[3] = 16'h007F; corners[4] = 16'h0080; corners[5] = 16'h7FFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 avail", host_avail, 0);
    chk("R1 busy", enc_busy, 0);
    chk("R1 ready", rpt_ready, 1);
    chk("R1 byte", host_byte, 0);
    // R9 pop on empty queue
    cyc(0, 0, 0, 0, 1);
    // directed clamp corners and all button patterns, then drain
    for (int i = 0; i < 8; i++) begin
      cyc(1, corners[i % 6], corners[(i + 3) % 6], 3'(i), 0);
      for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0);
      for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 1);
    end
    // R6: fill until ready drops, offered reports ignored
    for (int i = 0; i < 30; i++) cyc(1, rnd_val(), rnd_val(), 3'($urandom), 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 1);
    // random phases alternating fill and drain regimes
    for (int ph = 0; ph < 40; ph++) begin
      int pp = (ph % 2) ? 80 : 15;
      for (int i = 0; i < 100; i++)
        cyc($urandom_range(0, 99) < 70, rnd_val(), rnd_val(), 3'($urandom),
            $urandom_range(0, 99) < pp);
    end
    for (int i = 0; i < 25; i++) cyc(0, 0, 0, 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule